// File: doc/BRIEF.md
# Parallel Lookahead First-Order Delta-Sigma Modulator

This block is a first-order lowpass delta-sigma modulator. It makes `LANES` single-bit modulator outputs in every fabric clock cycle instead of one. The output word feeds a high-speed serializer, so a slow fabric clock can supply a multi-gigabit one-bit stream. After analog lowpass filtering, that stream reproduces the input level. For good quality, the bit rate should be roughly ten to twenty times the highest signal frequency of interest.

The modulator is an overflowing accumulator, `ACC_W` bits wide. Each cycle the block takes one unsigned sample and treats it as held for `LANES` bit periods. It resolves all `LANES` carries of the repeated additions in parallel. It then jumps the single state variable forward by `LANES` additions in one step. Bit 0 of the word is the earliest bit in time, and the serializer must be set to send bit 0 first. The density of ones in the stream tends to `sample / 2^ACC_W`.

Top module: `lookahead_dsm`

## Requirements
- R1: On a clock edge where `rst_n` is low, the accumulator and `bits_o` are cleared to zero, and the next word after reset is computed from a zero state.
- R2: Bit k of a word (k = 0 earliest) is 1 exactly when the (k+1)-th addition of the held sample into the `ACC_W`-bit accumulator overflows past 2^ACC_W during that cycle.
- R3: After each cycle the accumulator equals (previous accumulator + LANES·sample) mod 2^ACC_W, so consecutive words form one unbroken bit sequence.
- R4: `bits_o` is registered: the word produced at an edge belongs to the sample present at that edge and appears one cycle after the sample is applied.
- R5: A sample of zero yields an all-zero word and leaves the accumulator unchanged.
- R6: Starting from a zero state, the number of ones over M words with a constant sample x is exactly floor(M·LANES·x / 2^ACC_W).
- R7: With x = 2^ACC_W / LANES starting from zero, only the last lane (bit LANES-1) carries in each word, and the accumulator returns to zero at every word boundary.
- R8: With the full-scale sample 2^ACC_W − 1 from a zero state, the first word has every bit set except bit 0, and the following word is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, one word per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | ACC_W | Unsigned input sample, held for LANES bit periods |
| bits_o | output | LANES | Registered output word, bit 0 earliest in time |

## Verification
Two functions can coincide in one cycle: a carry in the last lane of a word, and the wrap of the state jump back past 2^ACC_W. The bench forces them together with a sample of 2^ACC_W/LANES, so the accumulator lands exactly on the modulus at the word boundary. It also uses full-scale input and a long pseudo-random run, where wraps fall at every lane position. Every output bit is judged against a bit-serial reference accumulator stepped LANES times per cycle. The totals of ones are judged against a closed-form count. A reset asserted mid-stream is checked by confirming that the next word restarts from a zero state.

// File: rtl/dsm_pkg.sv
// Package: shared width helpers for the lookahead modulator.
// Assumes LANES >= 1 and ACC_W >= 2.
package dsm_pkg;

    // Width that holds acc + lanes*x without loss for x < 2^acc_w.
    function automatic int sum_width(input int acc_w, input int lanes);
        return acc_w + $clog2(lanes + 1) + 1;
    endfunction

endpackage

// File: rtl/dsm_lane_carries.sv
// Module: computes the carry of each of LANES successive additions of the
// held sample into the accumulator, all in parallel.
// Assumes sample < 2^ACC_W, so adjacent partial sums differ in their upper
// part by 0 or 1. Lane 0 is the earliest bit in time.
module dsm_lane_carries #(
    parameter int LANES = 16,
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] sample_i,
    output logic [LANES-1:0] lanes_o
);
    localparam int SW = dsm_pkg::sum_width(ACC_W, LANES);
    localparam int HW = SW - ACC_W;

    logic [HW-1:0] upper [LANES+1];

    // Upper part of acc + k*sample for every k from 0 to LANES.
    for (genvar k = 0; k <= LANES; k++) begin : g_partial
        localparam logic [SW-1:0] KMUL = SW'(k);
        logic [SW-1:0] part;
        always_comb part = SW'(acc_i) + KMUL * SW'(sample_i);
        assign upper[k] = part[SW-1:ACC_W];
    end

    // A lane carries when its partial sum crosses into the next multiple of 2^ACC_W.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes_o[k] = (upper[k+1] != upper[k]);
    end
endmodule

// File: rtl/dsm_state_jump.sv
// Module: advances the accumulator by LANES additions of the sample in one
// step, and reports how many carries those additions produce in total.
// Assumes sample < 2^ACC_W.
module dsm_state_jump #(
    parameter int LANES = 16,
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] sample_i,
    output logic [ACC_W-1:0] acc_next_o,
    output logic [dsm_pkg::sum_width(ACC_W, LANES)-ACC_W-1:0] carry_total_o
);
    localparam int SW = dsm_pkg::sum_width(ACC_W, LANES);
    localparam logic [SW-1:0] NMUL = SW'(LANES);

    logic [SW-1:0] total;

    // Full-width sum of the state and LANES copies of the sample.
    always_comb total = SW'(acc_i) + NMUL * SW'(sample_i);

    assign acc_next_o    = total[ACC_W-1:0];
    assign carry_total_o = total[SW-1:ACC_W];
endmodule

// File: rtl/lookahead_dsm.sv
// Module: top of the parallel lookahead first-order delta-sigma modulator.
// Each clock it registers a LANES-bit word (bit 0 earliest) and the
// accumulator value LANES bit periods ahead. Synchronous active-low reset.
module lookahead_dsm #(
    parameter int LANES = 16,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] sample_i,
    output logic [LANES-1:0] bits_o
);
    localparam int SW = dsm_pkg::sum_width(ACC_W, LANES);
    localparam int HW = SW - ACC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;
    logic [HW-1:0]    carry_total;
    logic [LANES-1:0] lane_bits;

    dsm_lane_carries #(.LANES(LANES), .ACC_W(ACC_W)) u_lanes (
        .acc_i    (acc_q),
        .sample_i (sample_i),
        .lanes_o  (lane_bits)
    );

    dsm_state_jump #(.LANES(LANES), .ACC_W(ACC_W)) u_jump (
        .acc_i         (acc_q),
        .sample_i      (sample_i),
        .acc_next_o    (acc_next),
        .carry_total_o (carry_total)
    );

    // Register the state jump and the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            bits_o <= '0;
        end else begin
            acc_q  <= acc_next;
            bits_o <= lane_bits;
        end
    end

    // R1: reset clears the output word
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (bits_o == '0));

    // R5: zero sample gives an empty word
    a_r5_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i == '0) |=> (bits_o == '0));

    // R5: zero sample leaves the state alone
    a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i == '0) |=> (acc_q == $past(acc_q)));

    // R2 and R3: lane carries agree with the carry count of the state jump
    a_r2_carry_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_bits) == int'(carry_total));
endmodule

// File: tb/tb_lookahead_dsm.sv
`timescale 1ns/1ps
module tb_lookahead_dsm;
    localparam int LANES = 16;
    localparam int ACC_W = 16;
    localparam int MODV  = 1 << ACC_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ACC_W-1:0] sample_i = '0;
    logic [LANES-1:0] bits_o;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_acc  = 0;
    bit done     = 1'b0;

    lookahead_dsm #(.LANES(LANES), .ACC_W(ACC_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .bits_o   (bits_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Bit-serial reference: LANES single additions, lane 0 first.
    function automatic logic [LANES-1:0] ref_word(input int x);
        logic [LANES-1:0] w = '0;
        for (int k = 0; k < LANES; k++) begin
            ref_acc = ref_acc + x;
            if (ref_acc >= MODV) begin
                w[k] = 1'b1;
                ref_acc = ref_acc - MODV;
            end
        end
        return w;
    endfunction

    // Apply one sample at a negedge, check its word one cycle later (R4).
    task automatic run_word(input int x, input string req, output logic [LANES-1:0] got);
        logic [LANES-1:0] exp;
        sample_i = ACC_W'(x);
        @(posedge clk);
        exp = ref_word(x);
        @(negedge clk);
        got = bits_o;
        check(got == exp, req, got, exp);
    endtask

    task automatic do_reset(input int x);
        rst_n = 1'b0;
        sample_i = ACC_W'(x);
        @(posedge clk);
        @(negedge clk);
        ref_acc = 0;
        check(bits_o == '0, "R1 reset word", bits_o, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_restart();
        logic [LANES-1:0] g;
        do_reset(16'h1234);
        run_word(16'h0123, "R2 first word", g);
        run_word(16'h0123, "R3 second word", g);
        do_reset(16'hFFFF);   // mid-stream reset with a nonzero sample
        run_word(16'h0123, "R1 restart from zero state", g);
    endtask

    task automatic t_zero();
        logic [LANES-1:0] g;
        run_word(16'h7777, "R2 prime", g);
        run_word(0, "R5 zero word", g);
        check(g == '0, "R5 zero word literal", g, 0);
        run_word(16'h0FFF, "R5 state kept across zero", g);
    endtask

    task automatic t_density(input int x, input int words);
        logic [LANES-1:0] g;
        int ones = 0;
        longint exp;
        do_reset(0);
        for (int i = 0; i < words; i++) begin
            run_word(x, "R6 word", g);
            ones += $countones(g);
        end
        exp = (longint'(words) * LANES * x) / MODV;
        check(ones == exp, "R6 ones count", ones, exp);
    endtask

    task automatic t_boundary();
        logic [LANES-1:0] g;
        do_reset(0);
        for (int i = 0; i < 3; i++) begin
            run_word(MODV / LANES, "R7 last lane", g);
            check(g == 16'h8000, "R7 only top bit", g, 16'h8000);
        end
        run_word(16'h0800, "R7 state back to zero", g);
        check(g == 16'h0000, "R7 half step no carry", g, 0);
    endtask

    task automatic t_full_scale();
        logic [LANES-1:0] g;
        do_reset(0);
        run_word(MODV - 1, "R8 first word", g);
        check(g == 16'hFFFE, "R8 first word pattern", g, 16'hFFFE);
        run_word(MODV - 1, "R8 second word", g);
        check(g == 16'hFFFF, "R8 second word pattern", g, 16'hFFFF);
    endtask

    task automatic t_latency();
        logic [LANES-1:0] g;
        do_reset(0);
        run_word(16'h4000, "R4 word follows its sample", g);
        check(g == 16'h8888, "R4 pattern", g, 16'h8888);
        run_word(0, "R4 next sample takes over", g);
        check(g == 16'h0000, "R4 zero after", g, 0);
    endtask

    task automatic t_random();
        logic [LANES-1:0] g;
        int lcg = 32'h1ACE;
        do_reset(0);
        for (int i = 0; i < 300; i++) begin
            lcg = lcg * 1103515245 + 12345;
            run_word((lcg >>> 8) & (MODV - 1), "R2 R3 random stream", g);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bits_o == '0, "R1 reset state", bits_o, 0);
        t_reset_restart();
        t_zero();
        t_latency();
        t_boundary();
        t_full_scale();
        t_density(16'h4000, 8);
        t_density(16'h3001, 40);
        t_density(16'h0001, 16);
        t_random();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            summary();
            $finish;
        end
    end
endmodule